// File: doc/BRIEF.md
# Hot-Plug Power State Controller

This block sequences a video redriver between three power states: power down, standby and active. It takes a host power-down bit, an asynchronous hot-plug detect input, a per-lane asynchronous signal-detect vector and a handful of configuration bits. From these it produces the power-down and standby status bits, a hot-plug output toward the source, per-lane enable gating, a receive-termination enable and a DDC buffer enable. Register storage, the serial configuration port and analog signal detection are outside the block. Their results arrive as plain inputs.

Hot-plug detect and signal detect each pass through a two-flop synchronizer. Power down is entered whenever the host asks for it, or when the synchronized hot-plug input is low and the hot-plug override is clear. On leaving power down the block enters standby, or goes straight to active when standby is disabled. Standby moves to active once any enabled lane has reported signal for a programmable number of consecutive cycles. Active falls back to standby once every enabled lane has been silent for the same number of cycles. All outputs are registered and change on the same edge as the state.

Top module: `hpc_power_ctrl`

## Requirements
- R1: During and after reset, before any state change, pd_status is 1 and standby_status, hpd_out, lane_en_out, rx_term_en and ddc_buf_en are all 0.
- R2: One cycle after host_pd is sampled high, the block is in power down (pd_status=1) and hpd_out is 0. Otherwise hpd_out equals the synchronized hot-plug input, one cycle later.
- R3: With hpd_override=0, a synchronized hot-plug input of 0 puts the block into power down on the next cycle.
- R4: With hpd_override=1, the hot-plug input is ignored for state decisions: with host_pd=0, the block leaves power down on the next cycle even while hot-plug detect is low.
- R5: On leaving power down, the block enters standby (standby_status=1) when standby_dis=0, and enters active (both status bits 0) when standby_dis=1.
- R6: Standby moves to active when the synchronized signal detect, ANDed with lane_en_cfg, is nonzero for qual_cycles consecutive cycles. A qual_cycles value of 0 acts as 1. Signal detect on a disabled lane has no effect.
- R7: Active returns to standby when no enabled lane has shown synchronized signal detect for qual_cycles consecutive cycles. This never happens while standby_dis=1, and standby_dis=1 also moves standby to active on the next cycle.
- R8: lane_en_out equals lane_en_cfg in active and is all zeros in power down and standby.
- R9: ddc_buf_en is 1 only when ddc_en_cfg=1, the synchronized hot-plug input is 1 and host_pd=0.
- R10: rx_term_en is 1 exactly when the synchronized hot-plug input is 1 and term_dis=0.
- R11: pd_status and standby_status are never both 1. Active is the state in which both are 0.
- R12: A change on hpd_in or sigdet_in reaches the logic after two synchronizer flops, so a change on hpd_in first shows on rx_term_en at the third rising edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_pd | input | 1 | Host-forced power down |
| hpd_in | input | 1 | Hot-plug detect from the sink, asynchronous |
| hpd_override | input | 1 | Ignore hot-plug detect for power-down decisions |
| standby_dis | input | 1 | Skip standby and go straight to active |
| term_dis | input | 1 | Force receive termination off |
| ddc_en_cfg | input | 1 | DDC buffer enable request |
| lane_en_cfg | input | NUM_LANES | Per-lane enable configuration |
| sigdet_in | input | NUM_LANES | Per-lane signal detect, asynchronous |
| qual_cycles | input | QUAL_W | Consecutive cycles needed to qualify a signal change |
| pd_status | output | 1 | In power down |
| standby_status | output | 1 | In standby |
| hpd_out | output | 1 | Hot-plug indication toward the source |
| lane_en_out | output | NUM_LANES | Gated lane enables |
| rx_term_en | output | 1 | Receive termination enable |
| ddc_buf_en | output | 1 | DDC buffer enable |

## Verification
The assertions assume that the configuration inputs (host_pd, overrides, lane_en_cfg, qual_cycles) are synchronous to clk, and that only hpd_in and sigdet_in may change at any time. The bench drives every input a short delay after a rising edge and holds it for whole cycles, so every input is stable at the sampling edge. A reference model in the bench delays the asynchronous inputs through its own two-stage history and tracks the qualification run as a plain integer. Each output is compared every cycle against this model, and directed checks cover disabled-lane signal detect, the zero qualification setting and the override paths.

// File: rtl/hpc_pkg.sv
package hpc_pkg;
    typedef enum logic [1:0] {
        PWR_DOWN = 2'd0,
        PWR_STBY = 2'd1,
        PWR_ACT  = 2'd2
    } pwr_state_e;
endpackage

// File: rtl/hpc_sync.sv
module hpc_sync #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] meta_d, meta_q, stab_d, stab_q;

    always_comb begin
        meta_d = async_in;
        stab_d = meta_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= meta_d;
            stab_q <= stab_d;
        end
    end

    assign sync_out = stab_q;
endmodule

// File: rtl/hpc_qual.sv
module hpc_qual #(
    parameter int QUAL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cond,
    input  logic              clear,
    input  logic [QUAL_W-1:0] limit,
    output logic              hit
);
    localparam logic [QUAL_W-1:0] CNT_MAX = '1;

    logic [QUAL_W-1:0] cnt_d, cnt_q;
    logic [QUAL_W:0]   lim_eff, cnt_inc;

    always_comb begin
        lim_eff = (limit == '0) ? (QUAL_W+1)'(1) : {1'b0, limit};
        cnt_inc = {1'b0, cnt_q} + 1'b1;
        hit     = cond && (cnt_inc >= lim_eff);
        if (clear || !cond)
            cnt_d = '0;
        else if (cnt_q == CNT_MAX)
            cnt_d = cnt_q;
        else
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R6 / R7: the run counter restarts whenever the qualifying condition drops
    p_run_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cond |=> cnt_q == '0);
endmodule

// File: rtl/hpc_power_ctrl.sv
module hpc_power_ctrl
    import hpc_pkg::*;
#(
    parameter int NUM_LANES = 4,
    parameter int QUAL_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_pd,
    input  logic                 hpd_in,
    input  logic                 hpd_override,
    input  logic                 standby_dis,
    input  logic                 term_dis,
    input  logic                 ddc_en_cfg,
    input  logic [NUM_LANES-1:0] lane_en_cfg,
    input  logic [NUM_LANES-1:0] sigdet_in,
    input  logic [QUAL_W-1:0]    qual_cycles,
    output logic                 pd_status,
    output logic                 standby_status,
    output logic                 hpd_out,
    output logic [NUM_LANES-1:0] lane_en_out,
    output logic                 rx_term_en,
    output logic                 ddc_buf_en
);
    typedef struct packed {
        pwr_state_e           state;
        logic                 pd_stat;
        logic                 sb_stat;
        logic                 hpd_out;
        logic [NUM_LANES-1:0] lanes;
        logic                 term;
        logic                 ddc;
    } ctrl_t;

    logic                 hpd_s;
    logic [NUM_LANES-1:0] sd_s;
    logic                 any_sd, pd_req;
    logic                 qual_cond, qual_clear, qual_hit;
    ctrl_t                r_d, r_q;

    hpc_sync #(.WIDTH(1)) u_hpd_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (hpd_in),
        .sync_out (hpd_s)
    );

    hpc_sync #(.WIDTH(NUM_LANES)) u_sd_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (sigdet_in),
        .sync_out (sd_s)
    );

    always_comb begin
        any_sd    = |(sd_s & lane_en_cfg);
        pd_req    = host_pd || (!hpd_s && !hpd_override);
        qual_cond = ((r_q.state == PWR_STBY) && any_sd) ||
                    ((r_q.state == PWR_ACT) && !any_sd);
    end

    hpc_qual #(.QUAL_W(QUAL_W)) u_qual (
        .clk   (clk),
        .rst_n (rst_n),
        .cond  (qual_cond),
        .clear (qual_clear),
        .limit (qual_cycles),
        .hit   (qual_hit)
    );

    always_comb begin
        r_d = r_q;
        if (pd_req) begin
            r_d.state = PWR_DOWN;
        end else begin
            case (r_q.state)
                PWR_DOWN: r_d.state = standby_dis ? PWR_ACT : PWR_STBY;
                PWR_STBY: if (standby_dis || qual_hit) r_d.state = PWR_ACT;
                PWR_ACT:  if (!standby_dis && qual_hit) r_d.state = PWR_STBY;
                default:  r_d.state = PWR_DOWN;
            endcase
        end
        r_d.pd_stat = (r_d.state == PWR_DOWN);
        r_d.sb_stat = (r_d.state == PWR_STBY);
        r_d.hpd_out = hpd_s && !host_pd;
        r_d.lanes   = (r_d.state == PWR_ACT) ? lane_en_cfg : '0;
        r_d.term    = hpd_s && !term_dis;
        r_d.ddc     = ddc_en_cfg && hpd_s && !host_pd;
    end

    always_comb qual_clear = (r_d.state != r_q.state);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: PWR_DOWN, pd_stat: 1'b1, sb_stat: 1'b0, hpd_out: 1'b0,
                     lanes: '0, term: 1'b0, ddc: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign pd_status      = r_q.pd_stat;
    assign standby_status = r_q.sb_stat;
    assign hpd_out        = r_q.hpd_out;
    assign lane_en_out    = r_q.lanes;
    assign rx_term_en     = r_q.term;
    assign ddc_buf_en     = r_q.ddc;

    p_host_pd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        host_pd |=> (pd_status && !hpd_out));

    p_hpd_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!hpd_s && !hpd_override) |=> pd_status);

    p_override_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_status && !host_pd && hpd_override) |=> !pd_status);

    p_exit_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pd_status) |-> (standby_status == !$past(standby_dis)));

    p_no_idle_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (standby_status && !any_sd && !standby_dis) |=> (lane_en_out == '0));

    p_no_standby_r7: assert property (@(posedge clk) disable iff (!rst_n)
        standby_dis |=> !standby_status);

    p_lanes_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_status || standby_status) |-> (lane_en_out == '0));

    p_ddc_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_pd || !hpd_s) |=> !ddc_buf_en);

    p_status_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pd_status, standby_status}));
endmodule

// File: tb/hpc_power_ctrl_test.sv
module hpc_power_ctrl_test;
    localparam int NL = 4;
    localparam int QW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_pd = 1'b1, hpd_in = 1'b0, hpd_override = 1'b0, standby_dis = 1'b0;
    logic term_dis = 1'b0, ddc_en_cfg = 1'b1;
    logic [NL-1:0] lane_en_cfg = 4'b0011, sigdet_in = '0;
    logic [QW-1:0] qual_cycles = 8'd4;
    logic pd_status, standby_status, hpd_out, rx_term_en, ddc_buf_en;
    logic [NL-1:0] lane_en_out;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    hpc_power_ctrl #(.NUM_LANES(NL), .QUAL_W(QW)) uut (
        .clk(clk), .rst_n(rst_n), .host_pd(host_pd), .hpd_in(hpd_in),
        .hpd_override(hpd_override), .standby_dis(standby_dis), .term_dis(term_dis),
        .ddc_en_cfg(ddc_en_cfg), .lane_en_cfg(lane_en_cfg), .sigdet_in(sigdet_in),
        .qual_cycles(qual_cycles), .pd_status(pd_status), .standby_status(standby_status),
        .hpd_out(hpd_out), .lane_en_out(lane_en_out), .rx_term_en(rx_term_en),
        .ddc_buf_en(ddc_buf_en)
    );

    // Reference model: 0 = power down, 1 = standby, 2 = active
    int m_st, m_run;
    logic m_h1, m_h2;
    logic [NL-1:0] m_s1, m_s2;
    logic e_pd, e_sb, e_hpd, e_term, e_ddc;
    logic [NL-1:0] e_lane;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_run = 0; m_h1 = 0; m_h2 = 0; m_s1 = '0; m_s2 = '0;
            e_pd = 1; e_sb = 0; e_hpd = 0; e_term = 0; e_ddc = 0; e_lane = '0;
        end else begin
            logic any, pdc, cnd, hit;
            int q, nst;
            any = |(m_s2 & lane_en_cfg);
            pdc = host_pd || (!m_h2 && !hpd_override);
            cnd = (m_st == 1) ? any : (m_st == 2) ? !any : 1'b0;
            q   = (qual_cycles == 0) ? 1 : int'(qual_cycles);
            hit = cnd && (m_run + 1 >= q);
            nst = m_st;
            if (pdc) nst = 0;
            else if (m_st == 0) nst = standby_dis ? 2 : 1;
            else if (m_st == 1 && (standby_dis || hit)) nst = 2;
            else if (m_st == 2 && !standby_dis && hit) nst = 1;
            m_run = (nst != m_st || !cnd) ? 0 : m_run + 1;
            m_st = nst;
            e_pd = (m_st == 0); e_sb = (m_st == 1);
            e_hpd = m_h2 && !host_pd;
            e_lane = (m_st == 2) ? lane_en_cfg : '0;
            e_term = m_h2 && !term_dis;
            e_ddc = ddc_en_cfg && m_h2 && !host_pd;
            m_h2 = m_h1; m_h1 = hpd_in;
            m_s2 = m_s1; m_s1 = sigdet_in;
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R11 pd_status", {7'd0, pd_status}, {7'd0, e_pd});
        chk("R5 standby_status", {7'd0, standby_status}, {7'd0, e_sb});
        chk("R2 hpd_out", {7'd0, hpd_out}, {7'd0, e_hpd});
        chk("R8 lane_en_out", {4'd0, lane_en_out}, {4'd0, e_lane});
        chk("R10 rx_term_en", {7'd0, rx_term_en}, {7'd0, e_term});
        chk("R9 ddc_buf_en", {7'd0, ddc_buf_en}, {7'd0, e_ddc});
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
            compare_all();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1: reset values
        chk("R1 pd_status", {7'd0, pd_status}, 8'd1);
        chk("R1 outputs", {3'd0, standby_status, hpd_out, rx_term_en, ddc_buf_en, 1'b0}, 8'd0);
        chk("R1 lanes", {4'd0, lane_en_out}, 8'd0);
        rst_n = 1'b1;
        tick(2);
        chk("R1 after release", {7'd0, pd_status}, 8'd1);

        // R12: hpd_in reaches rx_term_en on the third edge
        hpd_in = 1'b1;
        tick(2);
        chk("R12 term early", {7'd0, rx_term_en}, 8'd0);
        tick(1);
        chk("R12 term on time", {7'd0, rx_term_en}, 8'd1);
        chk("R2 hpd_out under host_pd", {7'd0, hpd_out}, 8'd0);
        chk("R9 ddc under host_pd", {7'd0, ddc_buf_en}, 8'd0);

        // R5: exit to standby
        host_pd = 1'b0;
        tick(2);
        chk("R5 standby entered", {6'd0, pd_status, standby_status}, 8'd1);
        chk("R9 ddc enabled", {7'd0, ddc_buf_en}, 8'd1);

        // R6: signal on a disabled lane is ignored
        sigdet_in = 4'b0100;
        tick(20);
        chk("R6 disabled lane ignored", {7'd0, standby_status}, 8'd1);

        // R6: qualified signal wakes to active
        sigdet_in = 4'b0001;
        tick(10);
        chk("R6 active", {4'd0, lane_en_out}, 8'h03);

        // R7: loss of signal returns to standby
        sigdet_in = 4'b0000;
        tick(10);
        chk("R7 back to standby", {7'd0, standby_status}, 8'd1);

        // R7: standby disabled forces active and holds it
        standby_dis = 1'b1;
        tick(20);
        chk("R7 held active", {6'd0, pd_status, standby_status}, 8'd0);

        // R10: termination disable
        term_dis = 1'b1;
        tick(3);
        chk("R10 term off", {7'd0, rx_term_en}, 8'd0);
        term_dis = 1'b0;

        // R3: hot-plug low powers down
        hpd_in = 1'b0;
        tick(4);
        chk("R3 power down", {6'd0, pd_status, hpd_out}, 8'h02);

        // R4: override ignores hot-plug, R5 direct to active
        hpd_override = 1'b1;
        tick(2);
        chk("R4 override exit", {6'd0, pd_status, standby_status}, 8'd0);

        // R2: host power down
        host_pd = 1'b1;
        tick(2);
        chk("R2 host pd", {6'd0, pd_status, hpd_out}, 8'h02);

        // R6: zero qualification acts as one cycle
        host_pd = 1'b0; hpd_override = 1'b0; hpd_in = 1'b1; standby_dis = 1'b0;
        qual_cycles = 8'd0; ddc_en_cfg = 1'b0;
        tick(6);
        chk("R9 ddc cfg off", {7'd0, ddc_buf_en}, 8'd0);
        sigdet_in = 4'b0010;
        tick(4);
        chk("R6 zero qual active", {4'd0, lane_en_out}, 8'h03);
        sigdet_in = 4'b0000;
        tick(4);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule